// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs single read and write transfers on an external bus where one set of wires carries the address first and the data after it. A request gives the address, the direction, whether the read is an instruction fetch or a data access, an optional extra address phase, and a wait-state count. The block then steps through fixed phases. It raises an address-latch strobe, drops it, pulses an active-low read or write strobe, and recovers. It turns the bus around between driving and listening. It returns the read data and a one-cycle done pulse.

The block is clocked at twice the system clock rate. One cycle of `clk` is therefore one half-period of the system clock, and every strobe edge falls on a half-period boundary. All lengths below are given in `clk` cycles (half-periods). A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The first address phase starts on the cycle after that edge.

Top module: `extbus_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises, `bus_ale`=0, `bus_rd_n`=1, `bus_wr_n`=1, `bus_oe`=0, `rsp_done`=0 and `req_ready`=1.
- R2: After acceptance, `bus_ale` is 1 for 1 cycle, or for 3 cycles when `req_addr_wait` was 1. During those cycles `bus_oe`=1 and `bus_ad_out` carries the zero-extended address.
- R3: `bus_ale` is then 0 for exactly one cycle before the read or write strobe falls, with the address still driven (`bus_oe`=1). The time from address valid to strobe fall is therefore 2 cycles, or 4 with address wait.
- R4: The read or write strobe stays low for 3 + 2·n cycles, where n is the 3-bit `req_wait` value (0 to 7). Only the strobe matching `req_write` moves, and the two are never low together.
- R5: During a read, `bus_oe` is 0 from the cycle the read strobe falls. Address drive is released at that edge.
- R6: On a read, `bus_ad_in` is captured on the edge where `bus_rd_n` rises. The value appears on `rsp_rdata` no later than the done cycle and holds until the next read capture.
- R7: After a read strobe rises, the bus stays idle and undriven for 1 cycle when `req_fetch`=1 and for 3 cycles when `req_fetch`=0. Only then can a new address phase begin.
- R8: During a write, `bus_oe`=1 and `bus_ad_out` carries the zero-extended write data for every cycle `bus_wr_n` is low, and for one further cycle after it rises.
- R9: `rsp_done` is high for exactly one cycle, the cycle after the last recovery cycle. `req_ready` is high in that cycle.
- R10: `req_ready` is 0 from the first address cycle through the last recovery cycle. `req_valid` and the request fields are ignored in that span, so the running transfer is unaffected by them.
- R11: A request held valid during the done cycle is accepted there, and its first address cycle follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the system rate (one cycle = half system period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request accepted when both high |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch (short read recovery), 0 = data access |
| req_addr_wait | input | 1 | Adds one full system period to the address strobe |
| req_wait | input | WAIT_W (3) | Wait states n added to the strobe low time |
| req_addr | input | ADDR_W (16) | Transfer address |
| req_wdata | input | DATA_W (16) | Write data |
| rsp_rdata | output | DATA_W (16) | Last captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_ale | output | 1 | Address-latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Drive enable for the multiplexed bus |
| bus_ad_out | output | BUS_W (16) | Value driven onto the multiplexed bus |
| bus_ad_in | input | BUS_W (16) | Value sampled from the multiplexed bus |

## Verification
The bench runs reads with and without the address-wait phase, and with wait counts of 0, 3 and 7. This separates the address-stretch length from the strobe-width length. Fetch and data reads with the same address and wait count differ only in recovery length, so a swapped recovery shows up cycle by cycle. Writes check that the bus switches from address to data at the strobe fall and holds the data one cycle past the strobe rise. A request left valid with changed fields during a transfer shows whether it is wrongly taken while busy and whether it is correctly taken in the done cycle.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ADDR = 3'd1,
      PH_HOLD = 3'd2,
      PH_STRB = 3'd3,
      PH_RECV = 3'd4
   } phase_e;

   localparam int unsigned FETCH_RECOVER = 1;
   localparam int unsigned DATA_RECOVER  = 3;

endpackage

// File: rtl/extbus_timer.sv
module extbus_timer #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             cnt_zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/extbus_phase_fsm.sv
module extbus_phase_fsm
   import extbus_pkg::*;
#(
   parameter int unsigned WAIT_W = 3,
   parameter int unsigned CNT_W  = WAIT_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_addr_wait,
   input  logic              is_write,
   input  logic              is_fetch,
   input  logic [WAIT_W-1:0] wait_n,
   input  logic              cnt_zero,
   output phase_e            phase,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output logic              capture,
   output logic              done
);

   localparam logic [CNT_W-1:0] ADDR_EXTRA = CNT_W'(2);
   localparam logic [CNT_W-1:0] STRB_BASE  = CNT_W'(2);
   localparam logic [CNT_W-1:0] RECV_DATA  = CNT_W'(DATA_RECOVER - 1);
   localparam logic [CNT_W-1:0] RECV_FETCH = CNT_W'(FETCH_RECOVER - 1);

   phase_e phase_q, phase_d;
   logic   finish;

   always_comb begin
      phase_d  = phase_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      finish   = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               phase_d  = PH_ADDR;
               tmr_load = 1'b1;
               tmr_val  = start_addr_wait ? ADDR_EXTRA : '0;
            end
         end
         PH_ADDR: begin
            if (cnt_zero) phase_d = PH_HOLD;
         end
         PH_HOLD: begin
            phase_d  = PH_STRB;
            tmr_load = 1'b1;
            tmr_val  = {1'b0, wait_n, 1'b0} + STRB_BASE;
         end
         PH_STRB: begin
            if (cnt_zero) begin
               phase_d  = PH_RECV;
               tmr_load = 1'b1;
               tmr_val  = (!is_write && !is_fetch) ? RECV_DATA : RECV_FETCH;
               capture  = !is_write;
            end
         end
         PH_RECV: begin
            if (cnt_zero) begin
               phase_d = PH_IDLE;
               finish  = 1'b1;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done    <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done    <= finish;
      end
   end

   assign phase = phase_q;

endmodule

// File: rtl/extbus_bus_drive.sv
module extbus_bus_drive
   import extbus_pkg::*;
#(
   parameter int unsigned BUS_W = 16
) (
   input  phase_e           phase,
   input  logic             is_write,
   input  logic [BUS_W-1:0] addr_bus,
   input  logic [BUS_W-1:0] wdata_bus,
   output logic             ale,
   output logic             rd_n,
   output logic             wr_n,
   output logic             oe,
   output logic [BUS_W-1:0] ad_out
);

   logic addr_ph;
   logic data_ph;

   always_comb begin
      addr_ph = (phase == PH_ADDR) || (phase == PH_HOLD);
      data_ph = is_write && ((phase == PH_STRB) || (phase == PH_RECV));
      ale     = (phase == PH_ADDR);
      rd_n    = !((phase == PH_STRB) && !is_write);
      wr_n    = !((phase == PH_STRB) && is_write);
      oe      = addr_ph || data_ph;
      ad_out  = addr_ph ? addr_bus : wdata_bus;
   end

endmodule

// File: rtl/extbus_rd_capture.sv
module extbus_rd_capture #(
   parameter int unsigned BUS_W  = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [BUS_W-1:0]  ad_in,
   output logic [DATA_W-1:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (capture) begin
         rdata <= ad_in[DATA_W-1:0];
      end
   end

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
   import extbus_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned BUS_W  = 16,
   parameter int unsigned WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_fetch,
   input  logic              req_addr_wait,
   input  logic [WAIT_W-1:0] req_wait,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic              bus_ale,
   output logic              bus_rd_n,
   output logic              bus_wr_n,
   output logic              bus_oe,
   output logic [BUS_W-1:0]  bus_ad_out,
   input  logic [BUS_W-1:0]  bus_ad_in
);

   localparam int unsigned CNT_W = WAIT_W + 2;

   if (ADDR_W > BUS_W || ADDR_W < 1) begin : g_bad_addr
      $error("extbus_seq: ADDR_W must be 1..BUS_W");
   end
   if (DATA_W > BUS_W || DATA_W < 1) begin : g_bad_data
      $error("extbus_seq: DATA_W must be 1..BUS_W");
   end
   if (WAIT_W < 1 || WAIT_W > 6) begin : g_bad_wait
      $error("extbus_seq: WAIT_W must be 1..6");
   end

   phase_e             phase;
   logic               accept;
   logic               tmr_load;
   logic [CNT_W-1:0]   tmr_val;
   logic               cnt_zero;
   logic               capture;
   logic [BUS_W-1:0]   addr_bus;
   logic [BUS_W-1:0]   wdata_bus;

   logic               write_q;
   logic               fetch_q;
   logic [WAIT_W-1:0]  wait_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  wdata_q;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         write_q <= 1'b0;
         fetch_q <= 1'b0;
         wait_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         write_q <= req_write;
         fetch_q <= req_fetch;
         wait_q  <= req_wait;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   if (ADDR_W == BUS_W) begin : g_addr_full
      assign addr_bus = addr_q;
   end else begin : g_addr_ext
      assign addr_bus = {{(BUS_W-ADDR_W){1'b0}}, addr_q};
   end

   if (DATA_W == BUS_W) begin : g_data_full
      assign wdata_bus = wdata_q;
   end else begin : g_data_ext
      assign wdata_bus = {{(BUS_W-DATA_W){1'b0}}, wdata_q};
   end

   extbus_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .cnt_zero (cnt_zero)
   );

   extbus_phase_fsm #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .start           (accept),
      .start_addr_wait (req_addr_wait),
      .is_write        (write_q),
      .is_fetch        (fetch_q),
      .wait_n          (wait_q),
      .cnt_zero        (cnt_zero),
      .phase           (phase),
      .tmr_load        (tmr_load),
      .tmr_val         (tmr_val),
      .capture         (capture),
      .done            (rsp_done)
   );

   extbus_bus_drive #(.BUS_W(BUS_W)) u_drive (
      .phase     (phase),
      .is_write  (write_q),
      .addr_bus  (addr_bus),
      .wdata_bus (wdata_bus),
      .ale       (bus_ale),
      .rd_n      (bus_rd_n),
      .wr_n      (bus_wr_n),
      .oe        (bus_oe),
      .ad_out    (bus_ad_out)
   );

   extbus_rd_capture #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .ad_in   (bus_ad_in),
      .rdata   (rsp_rdata)
   );

endmodule

// File: rtl/extbus_seq_chk.sv
module extbus_seq_chk #(
   parameter int unsigned WAIT_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [WAIT_W-1:0] req_wait,
   input logic              bus_ale,
   input logic              bus_rd_n,
   input logic              bus_wr_n,
   input logic              bus_oe,
   input logic              rsp_done
);

   localparam int unsigned LEN_W = WAIT_W + 3;

   logic [WAIT_W-1:0] n_lat;
   logic [LEN_W-1:0]  low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_lat   <= '0;
         low_len <= '0;
      end else begin
         if (req_valid && req_ready) n_lat <= req_wait;
         if (!bus_rd_n || !bus_wr_n) low_len <= low_len + 1'b1;
         else                        low_len <= '0;
      end
   end

   assert_ale_vs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |-> (bus_rd_n && bus_wr_n));

   assert_gap_before_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> (!$past(bus_ale) && $past(bus_oe)));

   assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n));

   assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_rd_n) || $rose(bus_wr_n)) |->
         (low_len == LEN_W'(3) + {1'b0, n_lat, 1'b0}));

   assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_oe);

   assert_write_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> bus_oe);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);

   assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ale || !bus_rd_n || !bus_wr_n) |-> !req_ready);

endmodule

bind extbus_seq extbus_seq_chk #(.WAIT_W(WAIT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_wait  (req_wait),
   .bus_ale   (bus_ale),
   .bus_rd_n  (bus_rd_n),
   .bus_wr_n  (bus_wr_n),
   .bus_oe    (bus_oe),
   .rsp_done  (rsp_done)
);

// File: tb/extbus_seq_tb.sv
module extbus_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_fetch = 1'b0;
   logic        req_addr_wait = 1'b0;
   logic [2:0]  req_wait = '0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] rsp_rdata;
   logic        rsp_done;
   logic        bus_ale, bus_rd_n, bus_wr_n, bus_oe;
   logic [15:0] bus_ad_out;
   logic [15:0] bus_ad_in;
   logic [15:0] lat_addr = '0;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   extbus_seq u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_fetch(req_fetch),
      .req_addr_wait(req_addr_wait), .req_wait(req_wait),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
      .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
      .bus_oe(bus_oe), .bus_ad_out(bus_ad_out), .bus_ad_in(bus_ad_in)
   );

   // external memory: address latched while the strobe is high, data returned while read strobe low
   always_ff @(posedge clk) if (bus_ale) lat_addr <= bus_ad_out;
   assign bus_ad_in = !bus_rd_n ? (lat_addr ^ 16'hA5C3) : 16'h0F0F;

   typedef struct packed {
      logic        ale, rd_n, wr_n, oe, done, idle, rd;
      logic [15:0] ad;
   } exp_t;

   localparam exp_t IDLE_E = '{ale:1'b0, rd_n:1'b1, wr_n:1'b1, oe:1'b0, done:1'b0,
                              idle:1'b1, rd:1'b0, ad:16'h0};

   exp_t        q[$];
   exp_t        cur = IDLE_E;
   logic [15:0] exp_rdata = '0;
   logic [15:0] pend_rdata = '0;
   bit          last_acc = 0;

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic push_seq(input bit w, input bit f, input bit aw, input int n,
                           input logic [15:0] a, input logic [15:0] d);
      exp_t e;
      for (int i = 0; i < 1 + 2*aw; i++) begin
         e = '{ale:1'b1, rd_n:1'b1, wr_n:1'b1, oe:1'b1, done:1'b0, idle:1'b0, rd:1'b0, ad:a};
         q.push_back(e);
      end
      e = '{ale:1'b0, rd_n:1'b1, wr_n:1'b1, oe:1'b1, done:1'b0, idle:1'b0, rd:1'b0, ad:a};
      q.push_back(e);
      for (int i = 0; i < 3 + 2*n; i++) begin
         if (w) e = '{ale:1'b0, rd_n:1'b1, wr_n:1'b0, oe:1'b1, done:1'b0, idle:1'b0, rd:1'b0, ad:d};
         else   e = '{ale:1'b0, rd_n:1'b0, wr_n:1'b1, oe:1'b0, done:1'b0, idle:1'b0, rd:1'b0, ad:16'h0};
         q.push_back(e);
      end
      for (int i = 0; i < (w ? 1 : (f ? 1 : 3)); i++) begin
         if (w) e = '{ale:1'b0, rd_n:1'b1, wr_n:1'b1, oe:1'b1, done:1'b0, idle:1'b0, rd:1'b0, ad:d};
         else   e = '{ale:1'b0, rd_n:1'b1, wr_n:1'b1, oe:1'b0, done:1'b0, idle:1'b0, rd:1'b0, ad:16'h0};
         q.push_back(e);
      end
      e = '{ale:1'b0, rd_n:1'b1, wr_n:1'b1, oe:1'b0, done:1'b1, idle:1'b1, rd:!w, ad:16'h0};
      q.push_back(e);
      pend_rdata = a ^ 16'hA5C3;
   endtask

   task automatic compare();
      chk(bus_ale === cur.ale, "R2/R3 ale", {15'h0, bus_ale}, {15'h0, cur.ale});
      chk(bus_rd_n === cur.rd_n, "R4/R7 rd_n", {15'h0, bus_rd_n}, {15'h0, cur.rd_n});
      chk(bus_wr_n === cur.wr_n, "R4 wr_n", {15'h0, bus_wr_n}, {15'h0, cur.wr_n});
      chk(bus_oe === cur.oe, "R5/R8 oe", {15'h0, bus_oe}, {15'h0, cur.oe});
      if (cur.oe) chk(bus_ad_out === cur.ad, "R2/R8 ad_out", bus_ad_out, cur.ad);
      chk(rsp_done === cur.done, "R9 done", {15'h0, rsp_done}, {15'h0, cur.done});
      chk(req_ready === cur.idle, "R10 ready", {15'h0, req_ready}, {15'h0, cur.idle});
      if (cur.done && cur.rd) chk(rsp_rdata === exp_rdata, "R6 rdata", rsp_rdata, exp_rdata);
   endtask

   task automatic step();
      @(posedge clk);
      last_acc = req_valid && cur.idle;
      if (last_acc) push_seq(req_write, req_fetch, req_addr_wait, int'(req_wait), req_addr, req_wdata);
      cur = (q.size() > 0) ? q.pop_front() : IDLE_E;
      if (cur.done && cur.rd) exp_rdata = pend_rdata;
      @(negedge clk);
      compare();
   endtask

   task automatic issue(input bit w, input bit f, input bit aw, input int n,
                        input logic [15:0] a, input logic [15:0] d);
      req_write = w; req_fetch = f; req_addr_wait = aw;
      req_wait = 3'(n); req_addr = a; req_wdata = d;
      req_valid = 1'b1;
      do step(); while (!last_acc);
      req_valid = 1'b0;
   endtask

   task automatic finish_cycle();
      while (!cur.idle) step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog R9 actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(bus_ale === 1'b0 && bus_rd_n === 1'b1 && bus_wr_n === 1'b1 && bus_oe === 1'b0,
          "R1 strobes in reset", {12'h0, bus_ale, bus_rd_n, bus_wr_n, bus_oe}, 16'h0006);
      chk(rsp_done === 1'b0 && req_ready === 1'b1, "R1 done/ready in reset",
          {14'h0, rsp_done, req_ready}, 16'h0001);
      rst_n = 1'b1;
      step();
      chk(req_ready === 1'b1 && bus_oe === 1'b0, "R1 after reset",
          {14'h0, req_ready, bus_oe}, 16'h0002);

      // R2 R3 R4 R5 R6: plain data read, no waits
      issue(0, 0, 0, 0, 16'h1234, 16'h0); finish_cycle();
      // R7: fetch read vs data read, same fields otherwise
      issue(0, 1, 0, 3, 16'h2001, 16'h0); finish_cycle();
      issue(0, 0, 0, 3, 16'h2001, 16'h0); finish_cycle();
      // R2: address wait stretch, max waits R4
      issue(0, 0, 1, 7, 16'h8F0E, 16'h0); finish_cycle();
      // R8: writes
      issue(1, 0, 0, 0, 16'h00AA, 16'hBEEF); finish_cycle();
      issue(1, 1, 1, 5, 16'hC3C3, 16'h5A5A); finish_cycle();
      repeat (2) step();

      // R10 and R11: request held valid with changed fields during a busy transfer
      issue(0, 1, 0, 1, 16'h4444, 16'h0);
      req_write = 1'b1; req_fetch = 1'b0; req_addr_wait = 1'b1;
      req_wait = 3'd2; req_addr = 16'h7777; req_wdata = 16'h9999;
      req_valid = 1'b1;
      while (!cur.done) step();
      chk(rsp_rdata === (16'h4444 ^ 16'hA5C3), "R10 busy request did not disturb read",
          rsp_rdata, 16'h4444 ^ 16'hA5C3);
      step();
      chk(last_acc && bus_ale === 1'b1 && bus_ad_out === 16'h7777,
          "R11 accepted in done cycle", bus_ad_out, 16'h7777);
      req_valid = 1'b0;
      finish_cycle();
      // R11: back-to-back reads
      issue(0, 0, 0, 2, 16'h0101, 16'h0);
      req_write = 1'b0; req_fetch = 1'b1; req_addr_wait = 1'b0;
      req_wait = 3'd0; req_addr = 16'h0202; req_valid = 1'b1;
      while (!cur.done) step();
      step();
      req_valid = 1'b0;
      finish_cycle();
      repeat (3) step();

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule